// File: doc/BRIEF.md
# Dimmed Multiplexed Vacuum-Fluorescent Display Scanner

This block drives a multiplexed vacuum-fluorescent panel from a free-running oscillator clock. It gives each active digit a fixed time slot, one digit after another. During a slot it raises the enable line of that digit. At the same time it raises the segment enables that the display memory holds for that digit. The scan covers only the first N digit lines and then returns to the first line. N comes from a digit-count code, so one panel can use between four and eleven grid positions.

Brightness is set by pulse-width dimming inside each slot. A 10-bit dimmer code gives the on-time as a fraction of the slot, in steps of 1/1024, counted from the start of the slot. The on-fraction stops rising at 992/1024. Every slot therefore ends with a dark gap that keeps neighbouring digits apart. An active-low blank input, which may change at any time, forces all enables off. Software can load the memory and the codes while the panel is dark and release blank afterwards. The analog output stages and the oscillator are outside this block.

Top module: `vfd_scan_dimmer`

## Requirements
- R1: A digit slot lasts exactly 2048 clocks. With a 3.7 MHz clock this is about 554 µs per slot, and about 6.09 ms per frame with eleven digits.
- R2: The scan length N is the value of `digit_code`. Values below 4 count as 4 and values above 11 count as 11. Digit lines 0 to N-1 are visited in rising order and the scan then wraps to line 0, so the frame lasts 2048·N clocks.
- R3: Within a slot the outputs are lit for 2·min(code,992) clocks, starting at slot count 0. Code 0 lights nothing.
- R4: Every dimmer code of 992 or more gives 1984 lit clocks per slot, never more.
- R5: At most one bit of `digit_en` is high. `seg_en` is non-zero only while a digit is lit. Bit s of `seg_en` during digit d equals `disp_mem[d*43+s]`, with d and s counted from 0 and digit d on `digit_en[d]`.
- R6: While `blank_n` is low, every output is zero from the third rising edge after the low level is first sampled. Normal scanning resumes in the same way once `blank_n` returns high.
- R7: The dimmer code and the digit count are sampled only on the last clock of a slot. A change in the middle of a slot leaves the rest of that slot unchanged. If the new count is not larger than the next digit index, the scan restarts at line 0.
- R8: Reset clears all outputs. The first slot after reset uses digit 0 with a dimmer value of 0, so it is dark.
- R9: The outputs are registered. At each edge they show the slot state and the synchronized blank level of the previous cycle, so digit and segment lines change together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running scan oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blank_n | input | 1 | Asynchronous display enable; low forces all outputs off |
| dim_code | input | 10 | On-time code in steps of 1/1024 of a slot |
| digit_code | input | 4 | Number of scanned digits, clamped to 4..11 |
| disp_mem | input | 473 | Display memory, 43 bits per digit, digit 0 lowest |
| digit_en | output | 11 | One-hot digit enable, bit d = digit line d |
| seg_en | output | 43 | Segment enables for the lit digit |

## Verification
The assertions assume that `digit_code` and `dim_code` may change at any clock. They also assume that `blank_n` passes through the two-stage synchronizer and that reset is the only other source of darkness. The bench drives every input on the falling edge, so all inputs are stable at the sampling edge. It changes the codes both in the middle of a slot and just before the slot boundary. It holds blank low for many cycles so that the forced-dark window can be seen. The display memory is changed only between observations, which lets the reference model read the same value the block sees.

// File: rtl/vfd_scan_pkg.sv
package vfd_scan_pkg;

   // limit a requested count to the legal scan range
   function automatic int clamp_int(int v, int lo, int hi);
      if (v < lo) return lo;
      if (v > hi) return hi;
      return v;
   endfunction

   // variant selector for the slot counter
   typedef enum logic {CNT_WRAP_NATURAL = 1'b0, CNT_WRAP_COMPARE = 1'b1} cnt_kind_e;

endpackage

// File: rtl/vfd_blank_sync.sv
module vfd_blank_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic blank_n,
   output logic show_ok
);
   logic [STAGES-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-2:0], blank_n};
   end

   assign show_ok = sh_q[STAGES-1];
endmodule

// File: rtl/vfd_slot_seq.sv
module vfd_slot_seq
   import vfd_scan_pkg::*;
#(
   parameter int SLOT_CLKS = 2048,
   parameter int MAX_DIG   = 11,
   parameter int MIN_DIG   = 4,
   parameter int DIM_W     = 10
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [DIM_W-1:0]               dim_code,
   input  logic [$clog2(MAX_DIG+1)-1:0]   digit_code,
   output logic [$clog2(SLOT_CLKS)-1:0]   slot_cnt,
   output logic [$clog2(MAX_DIG)-1:0]     digit_idx,
   output logic [DIM_W-1:0]               dim_act
);
   localparam int SLOT_W = $clog2(SLOT_CLKS);
   localparam int IDX_W  = $clog2(MAX_DIG);
   localparam cnt_kind_e KIND = ((1 << SLOT_W) == SLOT_CLKS) ? CNT_WRAP_NATURAL
                                                             : CNT_WRAP_COMPARE;
   localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOT_CLKS - 1);

   logic              at_end;
   logic [SLOT_W-1:0] cnt_nxt;
   logic [IDX_W:0]    n_req;
   logic [IDX_W:0]    idx_inc;
   logic [IDX_W-1:0]  idx_nxt;

   assign at_end = (slot_cnt == LAST);

   generate
      if (KIND == CNT_WRAP_NATURAL) begin : g_pow2
         always_comb cnt_nxt = slot_cnt + 1'b1;
      end else begin : g_mod
         always_comb cnt_nxt = at_end ? '0 : slot_cnt + 1'b1;
      end
   endgenerate

   always_comb begin
      n_req   = (IDX_W+1)'(clamp_int(int'(digit_code), MIN_DIG, MAX_DIG));
      idx_inc = {1'b0, digit_idx} + 1'b1;
      idx_nxt = (idx_inc >= n_req) ? '0 : idx_inc[IDX_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_cnt  <= '0;
         digit_idx <= '0;
         dim_act   <= '0;
      end else begin
         slot_cnt <= cnt_nxt;
         if (at_end) begin
            digit_idx <= idx_nxt;
            dim_act   <= dim_code;
         end
      end
   end
endmodule

// File: rtl/vfd_dim_window.sv
module vfd_dim_window #(
   parameter int SLOT_W   = 11,
   parameter int DIM_W    = 10,
   parameter int DIM_SAT  = 992,
   parameter int SCALE_SH = 1
) (
   input  logic [SLOT_W-1:0] slot_cnt,
   input  logic [DIM_W-1:0]  dim_act,
   output logic              in_window
);
   localparam logic [DIM_W-1:0] SAT = DIM_W'(DIM_SAT);

   logic [DIM_W-1:0] dim_eff;
   logic [SLOT_W:0]  on_len;

   always_comb begin
      dim_eff   = (dim_act > SAT) ? SAT : dim_act;
      on_len    = (SLOT_W+1)'(dim_eff) << SCALE_SH;
      in_window = ({1'b0, slot_cnt} < on_len);
   end
endmodule

// File: rtl/vfd_out_stage.sv
module vfd_out_stage #(
   parameter int MAX_DIG = 11,
   parameter int NSEG    = 43,
   parameter int IDX_W   = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    show,
   input  logic [IDX_W-1:0]        digit_idx,
   input  logic [MAX_DIG*NSEG-1:0] disp_mem,
   output logic [MAX_DIG-1:0]      digit_en,
   output logic [NSEG-1:0]         seg_en
);
   logic [MAX_DIG-1:0] dsel;
   logic [NSEG-1:0]    masked [MAX_DIG];
   logic [NSEG-1:0]    seg_pick;

   generate
      for (genvar d = 0; d < MAX_DIG; d++) begin : g_dig
         assign dsel[d]   = (digit_idx == IDX_W'(d));
         assign masked[d] = disp_mem[d*NSEG +: NSEG] & {NSEG{dsel[d]}};
      end
   endgenerate

   always_comb begin
      seg_pick = '0;
      for (int d = 0; d < MAX_DIG; d++) seg_pick = seg_pick | masked[d];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         digit_en <= '0;
         seg_en   <= '0;
      end else begin
         digit_en <= show ? dsel : '0;
         seg_en   <= show ? seg_pick : '0;
      end
   end
endmodule

// File: rtl/vfd_scan_dimmer.sv
module vfd_scan_dimmer #(
   parameter int SLOT_CLKS   = 2048,
   parameter int MAX_DIG     = 11,
   parameter int MIN_DIG     = 4,
   parameter int NSEG        = 43,
   parameter int DIM_W       = 10,
   parameter int DIM_SAT     = 992,
   parameter int SYNC_STAGES = 2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           blank_n,
   input  logic [DIM_W-1:0]               dim_code,
   input  logic [$clog2(MAX_DIG+1)-1:0]   digit_code,
   input  logic [MAX_DIG*NSEG-1:0]        disp_mem,
   output logic [MAX_DIG-1:0]             digit_en,
   output logic [NSEG-1:0]                seg_en
);
   localparam int SLOT_W   = $clog2(SLOT_CLKS);
   localparam int IDX_W    = $clog2(MAX_DIG);
   localparam int SCALE_SH = SLOT_W - DIM_W;

   generate
      if (MAX_DIG < 2) begin : g_chk_dig
         $error("MAX_DIG must be at least 2");
      end
      if (MIN_DIG < 1 || MIN_DIG > MAX_DIG) begin : g_chk_min
         $error("MIN_DIG must lie in 1..MAX_DIG");
      end
      if (SLOT_CLKS < (1 << DIM_W)) begin : g_chk_slot
         $error("SLOT_CLKS must be at least 2**DIM_W");
      end
      if (DIM_SAT >= (1 << DIM_W)) begin : g_chk_sat
         $error("DIM_SAT must fit in DIM_W bits");
      end
      if ((DIM_SAT << SCALE_SH) >= SLOT_CLKS) begin : g_chk_gap
         $error("saturated on-time must leave a dark gap in each slot");
      end
      if (SYNC_STAGES < 2) begin : g_chk_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SLOT_W-1:0] slot_cnt;
   logic [IDX_W-1:0]  digit_idx;
   logic [DIM_W-1:0]  dim_act;
   logic              in_window;
   logic              show_ok;

   vfd_blank_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .blank_n(blank_n), .show_ok(show_ok)
   );

   vfd_slot_seq #(
      .SLOT_CLKS(SLOT_CLKS), .MAX_DIG(MAX_DIG), .MIN_DIG(MIN_DIG), .DIM_W(DIM_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .dim_code(dim_code), .digit_code(digit_code),
      .slot_cnt(slot_cnt), .digit_idx(digit_idx), .dim_act(dim_act)
   );

   vfd_dim_window #(
      .SLOT_W(SLOT_W), .DIM_W(DIM_W), .DIM_SAT(DIM_SAT), .SCALE_SH(SCALE_SH)
   ) u_win (
      .slot_cnt(slot_cnt), .dim_act(dim_act), .in_window(in_window)
   );

   vfd_out_stage #(.MAX_DIG(MAX_DIG), .NSEG(NSEG), .IDX_W(IDX_W)) u_out (
      .clk(clk), .rst_n(rst_n), .show(in_window & show_ok),
      .digit_idx(digit_idx), .disp_mem(disp_mem),
      .digit_en(digit_en), .seg_en(seg_en)
   );
endmodule

// File: rtl/vfd_scan_dimmer_chk.sv
module vfd_scan_dimmer_chk #(
   parameter int SLOT_CLKS = 2048,
   parameter int MAX_DIG   = 11,
   parameter int NSEG      = 43,
   parameter int DIM_W     = 10,
   parameter int DIM_SAT   = 992
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         blank_n,
   input logic [MAX_DIG-1:0]           digit_en,
   input logic [NSEG-1:0]              seg_en,
   input logic [$clog2(SLOT_CLKS)-1:0] slot_cnt,
   input logic [$clog2(MAX_DIG)-1:0]   digit_idx,
   input logic [DIM_W-1:0]             dim_act
);
   localparam int SLOT_W = $clog2(SLOT_CLKS);
   localparam int IDX_W  = $clog2(MAX_DIG);
   localparam logic [SLOT_W-1:0] LAST   = SLOT_W'(SLOT_CLKS - 1);
   localparam logic [SLOT_W-1:0] ON_CAP = SLOT_W'(DIM_SAT << (SLOT_W - DIM_W));

   a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_cnt != LAST) |=> (slot_cnt == $past(slot_cnt) + 1'b1));
   a_r1_count_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_cnt == LAST) |=> (slot_cnt == '0));
   a_r2_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, digit_idx} < (IDX_W+1)'(MAX_DIG)));
   a_r2_idx_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_cnt == LAST) |=> (digit_idx == '0 || digit_idx == $past(digit_idx) + 1'b1));
   a_r4_dark_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (|digit_en) |-> ($past(slot_cnt) < ON_CAP));
   a_r3_code_zero_dark: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(dim_act) == '0) |-> (digit_en == '0));
   a_r5_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(digit_en));
   a_r5_seg_needs_digit: assert property (@(posedge clk) disable iff (!rst_n)
      (|seg_en) |-> (|digit_en));
   a_r6_blank_dark: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(blank_n, 3) |-> (digit_en == '0 && seg_en == '0));
   a_r7_hold_mid_slot: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_cnt != LAST) |=> ($stable(digit_idx) && $stable(dim_act)));
endmodule

bind vfd_scan_dimmer vfd_scan_dimmer_chk #(
   .SLOT_CLKS(SLOT_CLKS), .MAX_DIG(MAX_DIG), .NSEG(NSEG),
   .DIM_W(DIM_W), .DIM_SAT(DIM_SAT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .blank_n(blank_n),
   .digit_en(digit_en), .seg_en(seg_en),
   .slot_cnt(slot_cnt), .digit_idx(digit_idx), .dim_act(dim_act)
);

// File: tb/vfd_scan_dimmer_test.sv
module vfd_scan_dimmer_test;
   localparam int NDIG = 11;
   localparam int NS   = 43;
   localparam int SLOT = 2048;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              blank_n = 1'b0;
   logic [9:0]        dim_code = '0;
   logic [3:0]        digit_code = 4'd4;
   logic [NDIG*NS-1:0] disp_mem;
   logic [NDIG-1:0]   digit_en;
   logic [NS-1:0]     seg_en;

   int tests = 0;
   int fails = 0;
   int cyc = 0;
   bit done = 0;

   vfd_scan_dimmer uut (
      .clk(clk), .rst_n(rst_n), .blank_n(blank_n), .dim_code(dim_code),
      .digit_code(digit_code), .disp_mem(disp_mem),
      .digit_en(digit_en), .seg_en(seg_en)
   );

   always #2 clk = ~clk;

   function automatic logic [NDIG*NS-1:0] pattern(int seed);
      logic [NDIG*NS-1:0] p;
      for (int i = 0; i < NDIG*NS; i++) p[i] = (((i * seed) + i / 7) % 3) == 0;
      return p;
   endfunction

   // behavioural reference model, advanced on each rising edge
   int m_cnt, m_idx, m_dim, bq0, bq1;
   logic [NDIG-1:0] e_dig;
   logic [NS-1:0]   e_seg;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt = 0; m_idx = 0; m_dim = 0; bq0 = 0; bq1 = 0;
         e_dig = '0; e_seg = '0;
      end else begin
         int lit, n;
         cyc++;
         lit = (m_dim > 992) ? 1984 : 2 * m_dim;
         if (bq1 != 0 && m_cnt < lit) begin
            e_dig = '0;
            e_dig[m_idx] = 1'b1;
            e_seg = disp_mem[m_idx*NS +: NS];
         end else begin
            e_dig = '0; e_seg = '0;
         end
         bq1 = bq0;
         bq0 = int'(blank_n);
         if (m_cnt == SLOT - 1) begin
            m_cnt = 0;
            n = int'(digit_code);
            if (n < 4) n = 4;
            if (n > 11) n = 11;
            m_idx = (m_idx + 1 >= n) ? 0 : m_idx + 1;
            m_dim = int'(dim_code);
         end else begin
            m_cnt++;
         end
      end
   end

   // per-cycle comparison and rise-time capture
   int rise_q[$];
   logic prev_d0 = 1'b0;
   always @(negedge clk) begin
      if (rst_n && !done) begin
         tests++;
         if (digit_en !== e_dig || seg_en !== e_seg) begin
            fails++;
            $display("FAIL R9 cycle %0d: digit_en=%h seg_en=%h expected %h %h",
                     cyc, digit_en, seg_en, e_dig, e_seg);
         end
         if (digit_en[0] && !prev_d0) rise_q.push_back(cyc);
         prev_d0 = digit_en[0];
      end
   end

   task automatic check(bit ok, string tag, longint act, longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic wait_state(int cnt);
      do @(negedge clk); while (m_cnt != cnt);
   endtask

   task automatic count_slot(output int lit);
      wait_state(0);
      lit = 0;
      repeat (SLOT) begin
         @(negedge clk);
         if (|digit_en) lit++;
      end
   endtask

   task automatic frame_period(output int per);
      rise_q.delete();
      while (rise_q.size() < 3) @(negedge clk);
      per = rise_q[2] - rise_q[1];
   endtask

   task automatic finish_run();
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      repeat (195000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
   end

   initial begin
      int lit, per, d;
      real us, ms;
      disp_mem = pattern(3);
      blank_n  = 1'b1;
      repeat (4) @(negedge clk);
      check(digit_en == '0 && seg_en == '0, "R8 reset outputs", digit_en, 0);
      rst_n = 1'b1;
      dim_code = 10'd512;

      // R8: first slot after reset is dark
      lit = 0;
      repeat (2040) begin @(negedge clk); if (|digit_en) lit++; end
      check(lit == 0, "R8 first slot dark", lit, 0);

      // R3: half brightness
      count_slot(lit);
      check(lit == 1024, "R3 code 512", lit, 1024);

      dim_code = 10'd0;   count_slot(lit);
      check(lit == 0, "R3 code 0", lit, 0);
      dim_code = 10'd991; count_slot(lit);
      check(lit == 1982, "R3 code 991", lit, 1982);
      dim_code = 10'd992; count_slot(lit);
      check(lit == 1984, "R4 code 992", lit, 1984);
      dim_code = 10'd1023; count_slot(lit);
      check(lit == 1984, "R4 code 1023", lit, 1984);

      // R7: mid-slot dimmer change waits for the boundary
      wait_state(500);
      dim_code = 10'd100;
      wait_state(1501);
      check(|digit_en, "R7 old code kept mid-slot", digit_en, 1);
      count_slot(lit);
      check(lit == 200, "R7 new code at boundary", lit, 200);

      // R2: clamped digit counts and frame length
      digit_code = 4'd3;
      frame_period(per);
      check(per == 4 * SLOT, "R2 count 3 clamps to 4", per, 4 * SLOT);
      digit_code = 4'd15;
      frame_period(per);
      check(per == 11 * SLOT, "R2 count 15 clamps to 11", per, 11 * SLOT);

      // R1: slot and frame time at 3.7 MHz
      us = (real'(per) / 11.0) / 3.7;
      ms = real'(per) / 3.7 / 1000.0;
      check(us > 553.0 && us < 555.0, "R1 slot microseconds", longint'(us), 554);
      check(ms > 6.08 && ms < 6.10, "R1 frame 0.01 ms", longint'(ms * 100.0), 609);

      // R7: shrinking the count below the next index wraps to line 0
      do @(negedge clk); while (!(m_idx == 8 && m_cnt == 10));
      digit_code = 4'd5;
      wait_state(0);
      @(negedge clk);
      check(digit_en == 11'b1, "R7 shrink wraps to digit 0", digit_en, 1);

      // R6: blanking mid window, then recovery
      wait_state(50);
      blank_n = 1'b0;
      repeat (3) @(negedge clk);
      check(digit_en == '0 && seg_en == '0, "R6 blank forces off", digit_en, 0);
      lit = 0;
      repeat (60) begin @(negedge clk); if (|digit_en || |seg_en) lit++; end
      check(lit == 0, "R6 stays off while blank low", lit, 0);
      blank_n = 1'b1;
      repeat (3) @(negedge clk);
      check(|digit_en, "R6 resumes after blank high", digit_en, 1);

      // R5: segment mapping for the lit digit
      disp_mem = pattern(5);
      wait_state(20);
      d = -1;
      for (int k = 0; k < NDIG; k++) if (digit_en[k]) d = k;
      check(d >= 0 && $countones(digit_en) == 1, "R5 one digit lit", $countones(digit_en), 1);
      if (d >= 0)
         check(seg_en == disp_mem[d*NS +: NS], "R5 segment slice",
               longint'(seg_en[31:0]), longint'(disp_mem[d*NS +: 32]));

      repeat (10) @(negedge clk);
      finish_run();
   end
endmodule